// File: doc/BRIEF.md
# Processor Configuration and Diagnostic Register Bank

This block holds three system-control registers that a processor core reads and writes by register number. The configuration word mixes strap-sampled read-only fields (bus clock ratio and writeback data pattern), hardwired constant bits, and a few software-writable bits: endian select, a spare bit with no hardware effect, and the cacheability code for the unmapped kernel segment. A second register records the physical address of the latest load-linked access and can also be overwritten by software. A third register carries an 8-bit diagnostic byte.

Writes are accepted on a single-cycle strobe and take effect at the next rising clock edge. Reads are combinational from the register number. The load-linked capture strobe carries its own address and wins over a same-cycle software write. Register numbers: configuration = 16, load-linked address = 17, diagnostic = 26. Every other number is unmapped.

Top module: `cop_cfg_regs`

## Requirements
- R1: While reset is held low, the configuration word is loaded so that bit 15 equals `strap_big_end`, bit 3 is 0 and bits 2:0 are 010. The load-linked register and the diagnostic register read 0.
- R2: Configuration bits 30:28 show the `strap_ratio` value and bits 27:24 show the `strap_wbpat` value, both as sampled in the last reset cycle. Later changes on the strap pins and software writes leave them unchanged.
- R3: A write to register 16 copies write-data bits 15, 3 and 2:0 into the same configuration bits, visible from the following cycle.
- R4: All configuration bits except 30:24, 15, 3 and 2:0 always read as the constant 0x00066460, whatever is written. Bit 31 is 0.
- R5: A load-linked capture loads the load-linked register with `ll_paddr` with bits 31:29 forced to 0.
- R6: A software write to register 17 sets all 32 bits of the load-linked register.
- R7: When a capture and a software write to register 17 occur in the same cycle, the register takes the capture value.
- R8: A write to register 26 stores write-data bits 7:0. Bits 31:8 of register 26 always read as 0.
- R9: Reading any unmapped register number returns 0, and writing one changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_ratio | input | 3 | Bus clock ratio strap, sampled during reset |
| strap_wbpat | input | 4 | Writeback data pattern strap, sampled during reset |
| strap_big_end | input | 1 | Endian reset value for configuration bit 15 |
| reg_wr_en | input | 1 | Software write strobe |
| reg_addr | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ll_capture | input | 1 | Load-linked address capture strobe |
| ll_paddr | input | 32 | Physical address of the load-linked access |

## Verification
Read data follows `reg_addr` within the same cycle, so the bench settles the address and samples one time unit later. A write or capture is driven on a falling edge and lands at the next rising edge. It is therefore checked at the falling edge that follows, one full cycle after the stimulus. Strap-derived fields are due after the first rising edge with reset low, and they are checked after reset is released and again after the straps are moved.

// File: rtl/cop_cfg_pkg.sv
// Package: shared widths, register numbers and field constants for the
// configuration/diagnostic register bank. Assumes a 32-bit data path.
package cop_cfg_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int RATIO_W    = 3;
    localparam int WBPAT_W    = 4;
    localparam int KSEG_W     = 3;
    localparam int DIAG_W     = 8;
    localparam int LL_ZERO_W  = 3;

    localparam logic [ADDR_W-1:0] REG_CFG  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] REG_LL   = ADDR_W'(17);
    localparam logic [ADDR_W-1:0] REG_DIAG = ADDR_W'(26);

    // constant bits of the configuration word and where they live
    localparam logic [DATA_W-1:0] CFG_CONST_VAL  = 32'h0006_6460;
    localparam logic [DATA_W-1:0] CFG_CONST_MASK = 32'h80FF_7FF0;

    localparam logic [KSEG_W-1:0] KSEG_RESET = 3'b010;

    // mask applied to a captured load-linked address
    localparam logic [DATA_W-1:0] LL_CAP_MASK = {{LL_ZERO_W{1'b0}}, {(DATA_W-LL_ZERO_W){1'b1}}};
endpackage

// File: rtl/cop_cfg_word.sv
// Module: configuration word. Holds strap-sampled read-only fields, three
// software-writable fields and the constant bits, and assembles the word.
// Assumes wr_en is already decoded for this register by the parent.
module cop_cfg_word
    import cop_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RATIO_W-1:0]  strap_ratio,
    input  logic [WBPAT_W-1:0]  strap_wbpat,
    input  logic                strap_big_end,
    input  logic                wr_en,
    input  logic                wr_big_end,
    input  logic                wr_spare,
    input  logic [KSEG_W-1:0]   wr_kseg,
    output logic [DATA_W-1:0]   word
);
    logic [RATIO_W-1:0] ratio_q;
    logic [WBPAT_W-1:0] wbpat_q;
    logic               big_end_q;
    logic               spare_q;
    logic [KSEG_W-1:0]  kseg_q;

    // sample straps during reset, hold them afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= strap_ratio;
            wbpat_q <= strap_wbpat;
        end
    end

    // software-writable fields with their reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_end_q <= strap_big_end;
            spare_q   <= 1'b0;
            kseg_q    <= KSEG_RESET;
        end else if (wr_en) begin
            big_end_q <= wr_big_end;
            spare_q   <= wr_spare;
            kseg_q    <= wr_kseg;
        end
    end

    // assemble the readable word from constants and fields
    always_comb begin
        word        = CFG_CONST_VAL;
        word[30:28] = ratio_q;
        word[27:24] = wbpat_q;
        word[15]    = big_end_q;
        word[3]     = spare_q;
        word[2:0]   = kseg_q;
    end

    p_ro_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(ratio_q) && $stable(wbpat_q)));

    p_kseg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (kseg_q == $past(wr_kseg) && big_end_q == $past(wr_big_end)));

    p_kseg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(kseg_q));
endmodule

// File: rtl/cop_ll_addr.sv
// Module: load-linked address register. Two writers: a hardware capture
// (upper bits forced to zero) and a full-width software write. Capture wins.
module cop_ll_addr
    import cop_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_paddr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] ll_q;

    // update from capture first, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ll_q <= '0;
        else if (capture)
            ll_q <= cap_paddr & LL_CAP_MASK;
        else if (wr_en)
            ll_q <= wr_data;
    end

    assign value = ll_q;

    p_cap_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ll_q[DATA_W-1 -: LL_ZERO_W] == '0));

    p_cap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && wr_en) |=> (ll_q[DATA_W-LL_ZERO_W-1:0] == $past(cap_paddr[DATA_W-LL_ZERO_W-1:0])));

    p_sw_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !capture) |=> (ll_q == $past(wr_data)));
endmodule

// File: rtl/cop_diag.sv
// Module: 8-bit diagnostic register, zero-extended on read.
module cop_diag
    import cop_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DIAG_W-1:0] wr_data,
    output logic [DATA_W-1:0] value
);
    logic [DIAG_W-1:0] diag_q;

    // store the low byte on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            diag_q <= '0;
        else if (wr_en)
            diag_q <= wr_data;
    end

    assign value = {{(DATA_W-DIAG_W){1'b0}}, diag_q};

    p_diag_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value[DIAG_W-1:0] == $past(wr_data)));
endmodule

// File: rtl/cop_cfg_regs.sv
// Module: top of the register bank. Decodes the register number for writes,
// drives the three registers and multiplexes read data combinationally.
// Assumes strap pins are stable while reset is held.
module cop_cfg_regs
    import cop_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          strap_ratio,
    input  logic [3:0]          strap_wbpat,
    input  logic                strap_big_end,
    input  logic                reg_wr_en,
    input  logic [4:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                ll_capture,
    input  logic [31:0]         ll_paddr
);
    logic              hit_cfg, hit_ll, hit_diag;
    logic [DATA_W-1:0] cfg_word, ll_word, diag_word;

    // register number decode
    always_comb begin
        hit_cfg  = (reg_addr == REG_CFG);
        hit_ll   = (reg_addr == REG_LL);
        hit_diag = (reg_addr == REG_DIAG);
    end

    cop_cfg_word u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_ratio   (strap_ratio),
        .strap_wbpat   (strap_wbpat),
        .strap_big_end (strap_big_end),
        .wr_en         (reg_wr_en && hit_cfg),
        .wr_big_end    (reg_wdata[15]),
        .wr_spare      (reg_wdata[3]),
        .wr_kseg       (reg_wdata[2:0]),
        .word          (cfg_word)
    );

    cop_ll_addr u_ll (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (ll_capture),
        .cap_paddr (ll_paddr),
        .wr_en     (reg_wr_en && hit_ll),
        .wr_data   (reg_wdata),
        .value     (ll_word)
    );

    cop_diag u_diag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en && hit_diag),
        .wr_data (reg_wdata[DIAG_W-1:0]),
        .value   (diag_word)
    );

    // read multiplexer, unmapped numbers read zero
    always_comb begin
        reg_rdata = '0;
        if (hit_cfg)  reg_rdata = cfg_word;
        if (hit_ll)   reg_rdata = ll_word;
        if (hit_diag) reg_rdata = diag_word;
    end

    p_cfg_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg |-> ((reg_rdata & CFG_CONST_MASK) == CFG_CONST_VAL));

    p_diag_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_diag |-> (reg_rdata[31:8] == '0));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_cfg || hit_ll || hit_diag) |-> (reg_rdata == '0));
endmodule

// File: tb/cop_cfg_regs_bench.sv
module cop_cfg_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_ratio = 3'b110;
    logic [3:0]  strap_wbpat = 4'b0000;
    logic        strap_big_end = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ll_capture = 1'b0;
    logic [31:0] ll_paddr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_CFG = 5'd16, A_LL = 5'd17, A_DIAG = 5'd26;

    always #2 clk = ~clk;

    cop_cfg_regs u_cop_cfg_regs (
        .clk(clk), .rst_n(rst_n), .strap_ratio(strap_ratio), .strap_wbpat(strap_wbpat),
        .strap_big_end(strap_big_end), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ll_capture(ll_capture), .ll_paddr(ll_paddr)
    );

    function automatic logic [31:0] cfg_exp(logic [2:0] r, logic [3:0] p, logic be, logic sp, logic [2:0] k);
        return {1'b0, r, p, 4'b0000, 2'b01, 1'b1, 1'b0, be, 1'b1, 1'b1, 1'b0,
                3'b010, 3'b001, 1'b1, 1'b0, sp, k};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_reset(logic [2:0] r, logic [3:0] p, logic be);
        @(negedge clk);
        rst_n = 1'b0; strap_ratio = r; strap_wbpat = p; strap_big_end = be;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] cur_cfg;

        // R1/R2: reset state over all strap combinations
        for (int s = 0; s < 256; s++) begin
            do_reset(s[2:0], s[6:3], s[7]);
            rd(A_CFG, d);  check("R1 R2 cfg reset", d, cfg_exp(s[2:0], s[6:3], s[7], 1'b0, 3'b010));
            rd(A_LL, d);   check("R1 ll reset", d, 32'h0);
            rd(A_DIAG, d); check("R1 diag reset", d, 32'h0);
        end

        do_reset(3'b111, 4'b0110, 1'b1);
        // R2: strap movement after reset has no effect
        @(negedge clk);
        strap_ratio = 3'b001; strap_wbpat = 4'b1001; strap_big_end = 1'b0;
        @(negedge clk);
        rd(A_CFG, d); check("R2 straps after reset", d, cfg_exp(3'b111, 4'b0110, 1'b1, 1'b0, 3'b010));

        // R3/R4/R2: walking ones, all-ones and zero writes to config
        for (int i = 0; i < 34; i++) begin
            logic [31:0] w;
            w = (i < 32) ? (32'h1 << i) : ((i == 32) ? 32'hFFFF_FFFF : 32'h0);
            wr(A_CFG, w);
            rd(A_CFG, d);
            check("R3 R4 cfg write", d, cfg_exp(3'b111, 4'b0110, w[15], w[3], w[2:0]));
        end
        cur_cfg = cfg_exp(3'b111, 4'b0110, 1'b0, 1'b0, 3'b000);
        // R3: every kseg value and spare/endian combination
        for (int k = 0; k < 32; k++) begin
            logic [31:0] w;
            w = {16'hA5A5, k[4], 11'h7F0, k[3], k[2:0]};
            wr(A_CFG, w);
            rd(A_CFG, d);
            cur_cfg = cfg_exp(3'b111, 4'b0110, k[4], k[3], k[2:0]);
            check("R3 cfg fields", d, cur_cfg);
        end

        // R5: captures force top three bits to zero
        for (int i = 0; i < 32; i++) begin
            logic [31:0] a;
            a = 32'hE000_0000 | (32'h1 << i) | (i * 32'h0101_0101);
            @(negedge clk); ll_capture = 1'b1; ll_paddr = a;
            @(negedge clk); ll_capture = 1'b0;
            rd(A_LL, d); check("R5 ll capture", d, a & 32'h1FFF_FFFF);
        end

        // R6: software write sets all 32 bits
        for (int i = 0; i < 32; i++) begin
            logic [31:0] w;
            w = ~(32'h1 << i);
            wr(A_LL, w);
            rd(A_LL, d); check("R6 ll software write", d, w);
        end

        // R7: same-cycle capture and write, capture wins
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            a = 32'hFFFF_0000 ^ (i * 32'h2468_1357);
            @(negedge clk);
            ll_capture = 1'b1; ll_paddr = a;
            reg_wr_en = 1'b1; reg_addr = A_LL; reg_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            ll_capture = 1'b0; reg_wr_en = 1'b0;
            rd(A_LL, d); check("R7 capture priority", d, a & 32'h1FFF_FFFF);
        end

        // R8: diagnostic byte sweep with upper bits set
        for (int i = 0; i < 256; i++) begin
            wr(A_DIAG, {~i[23:0], i[7:0]});
            rd(A_DIAG, d); check("R8 diag", d, {24'h0, i[7:0]});
        end

        // R9: unmapped writes and reads
        wr(A_LL, 32'h1234_5678);
        wr(A_DIAG, 32'h0000_005A);
        for (int a = 0; a < 32; a++) begin
            if (a != 16 && a != 17 && a != 26) begin
                wr(a[4:0], 32'hFFFF_FFFF);
                rd(a[4:0], d);  check("R9 unmapped read", d, 32'h0);
                rd(A_CFG, d);   check("R9 cfg untouched", d, cur_cfg);
                rd(A_LL, d);    check("R9 ll untouched", d, 32'h1234_5678);
                rd(A_DIAG, d);  check("R9 diag untouched", d, 32'h0000_005A);
            end
        end

        finish_run();
    end
endmodule